// File: doc/BRIEF.md
# Unified Memory Port Arbiter

This block sits in front of a single memory port that serves both the instruction fetch of a five-stage in-order pipeline and the load/store accesses made in its memory stage. Each cycle it may see a fetch request from the fetch stage and a data request from the memory stage. When only one side asks, that side gets the port. When both ask in the same cycle, the data access wins and the fetch is delayed. This resolves the structural hazard in which a load or store collides with the fetch of an instruction three slots younger.

The arbiter does not lose a delayed fetch. It keeps the fetch address in its own holding register and raises a fetch-stall output. While that stall is shown, the fetch stage keeps its program counter. The held fetch goes out as soon as the port is free. Any fetch request presented while the stall is shown is ignored in favour of the held one. The port outputs are registered, so the memory sees the winner's address, write enable and write data one cycle after the requests.

Top module: `sp_arb`

## Requirements
- R1: While rst_n is low, port_en, port_we, gnt_if, gnt_mem and if_stall are 0, and port_addr and port_wdata are 0, whatever the request inputs do.
- R2: A data request (mem_req=1) is granted in the next cycle with gnt_mem=1, port_en=1, port_addr equal to mem_addr, and port_we equal to mem_we. When mem_we=1, port_wdata equals mem_wdata.
- R3: A fetch request with no data request and no held fetch is granted in the next cycle with gnt_if=1, port_en=1, port_we=0 and port_addr equal to if_addr.
- R4: When a fetch (new or held) and a data request meet in the same cycle, the next cycle shows gnt_mem=1, gnt_if=0 and if_stall=1.
- R5: A fetch delayed under R4 is granted in the first later cycle with no data request, with port_addr equal to the delayed fetch address.
- R6: While if_stall=1, the values on if_req and if_addr have no effect. The held fetch is the one that competes for the port.
- R7: When data requests arrive back to back, a held fetch keeps waiting: if_stall stays 1 in every cycle the data side holds the port and a fetch is pending.
- R8: gnt_if and gnt_mem are never both 1. if_stall=1 only together with gnt_mem=1.
- R9: With no request and no held fetch, the next cycle shows port_en=0, gnt_if=0, gnt_mem=0, port_addr=0.
- R10: port_we=1 only in a cycle with gnt_mem=1. mem_we is ignored when mem_req=0. When port_we=0, port_wdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_req | input | 1 | Fetch request from the fetch stage |
| if_addr | input | AW | Fetch address |
| mem_req | input | 1 | Load/store request from the memory stage |
| mem_we | input | 1 | 1 for a store, 0 for a load |
| mem_addr | input | AW | Data address |
| mem_wdata | input | DW | Store data |
| port_en | output | 1 | Memory port access this cycle |
| port_we | output | 1 | Memory port write enable |
| port_addr | output | AW | Memory port address |
| port_wdata | output | DW | Memory port write data |
| gnt_if | output | 1 | Port given to the fetch side |
| gnt_mem | output | 1 | Port given to the data side |
| if_stall | output | 1 | Fetch delayed; the fetch stage holds its counter |

## Verification
Every result appears exactly one cycle after the requests that cause it. The port fields, grants and stall all come from one register stage, so the bench drives requests on a falling edge and compares all outputs on the following falling edge. A delayed fetch shows up at least two cycles after its request: one cycle of stall, then the grant in the first free cycle. The reference model therefore keeps pending fetch addresses in a queue and releases one only in a cycle with no data request. Back-to-back data requests, stall-time fetch changes and stray write enables are driven on purpose, and the bench then runs a stretch of random traffic.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;

  // Which requester owns the port in a given cycle
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_FETCH = 2'b01,
    OWN_DATA  = 2'b10
  } owner_e;

endpackage

// File: rtl/sp_arb_pick.sv
// Fixed-priority decision: the data access beats the fetch.
module sp_arb_pick
  import sp_arb_pkg::*;
(
  input  logic   fetch_vld,
  input  logic   data_vld,
  output owner_e owner,
  output logic   fetch_wait
);

  always_comb begin
    owner      = OWN_NONE;
    fetch_wait = 1'b0;
    if (data_vld) begin
      owner      = OWN_DATA;
      fetch_wait = fetch_vld;
    end else if (fetch_vld) begin
      owner = OWN_FETCH;
    end
  end

endmodule

// File: rtl/sp_arb_hold.sv
// Keeps a delayed fetch and presents it again in place of the live input.
module sp_arb_hold #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_req,
  input  logic [AW-1:0] if_addr,
  input  logic          fetch_wait,
  output logic          fetch_vld,
  output logic [AW-1:0] fetch_addr
);

  logic          held_q, held_d;
  logic [AW-1:0] hold_addr_q, hold_addr_d;
  logic          hold_en;

  // The held copy replaces the live request while a fetch is pending
  always_comb begin
    fetch_vld  = held_q | if_req;
    fetch_addr = held_q ? hold_addr_q : if_addr;
  end

  always_comb begin
    held_d      = fetch_wait;
    hold_en     = fetch_wait & ~held_q;
    hold_addr_d = if_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q      <= 1'b0;
      hold_addr_q <= '0;
    end else begin
      held_q <= held_d;
      if (hold_en) begin
        hold_addr_q <= hold_addr_d;
      end
    end
  end

endmodule

// File: rtl/sp_arb_port.sv
// Registered drive of the shared memory port and grant outputs.
module sp_arb_port
  import sp_arb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  owner_e        owner,
  input  logic          fetch_wait,
  input  logic [AW-1:0] fetch_addr,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  output logic          port_en,
  output logic          port_we,
  output logic [AW-1:0] port_addr,
  output logic [DW-1:0] port_wdata,
  output logic          gnt_if,
  output logic          gnt_mem,
  output logic          if_stall
);

  logic          en_d, we_d, gi_d, gm_d, st_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;

  always_comb begin
    en_d    = 1'b0;
    we_d    = 1'b0;
    gi_d    = 1'b0;
    gm_d    = 1'b0;
    st_d    = fetch_wait;
    addr_d  = '0;
    wdata_d = '0;
    unique case (owner)
      OWN_DATA: begin
        en_d   = 1'b1;
        gm_d   = 1'b1;
        we_d   = mem_we;
        addr_d = mem_addr;
        if (mem_we) wdata_d = mem_wdata;
      end
      OWN_FETCH: begin
        en_d   = 1'b1;
        gi_d   = 1'b1;
        addr_d = fetch_addr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_en    <= 1'b0;
      port_we    <= 1'b0;
      port_addr  <= '0;
      port_wdata <= '0;
      gnt_if     <= 1'b0;
      gnt_mem    <= 1'b0;
      if_stall   <= 1'b0;
    end else begin
      port_en    <= en_d;
      port_we    <= we_d;
      port_addr  <= addr_d;
      port_wdata <= wdata_d;
      gnt_if     <= gi_d;
      gnt_mem    <= gm_d;
      if_stall   <= st_d;
    end
  end

endmodule

// File: rtl/sp_arb.sv
module sp_arb
  import sp_arb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_req,
  input  logic [AW-1:0] if_addr,
  input  logic          mem_req,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  output logic          port_en,
  output logic          port_we,
  output logic [AW-1:0] port_addr,
  output logic [DW-1:0] port_wdata,
  output logic          gnt_if,
  output logic          gnt_mem,
  output logic          if_stall
);

  logic          fetch_vld;
  logic [AW-1:0] fetch_addr;
  logic          fetch_wait;
  owner_e        owner;

  sp_arb_hold #(.AW(AW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .if_req     (if_req),
    .if_addr    (if_addr),
    .fetch_wait (fetch_wait),
    .fetch_vld  (fetch_vld),
    .fetch_addr (fetch_addr)
  );

  sp_arb_pick u_pick (
    .fetch_vld  (fetch_vld),
    .data_vld   (mem_req),
    .owner      (owner),
    .fetch_wait (fetch_wait)
  );

  sp_arb_port #(.AW(AW), .DW(DW)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .owner      (owner),
    .fetch_wait (fetch_wait),
    .fetch_addr (fetch_addr),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .port_en    (port_en),
    .port_we    (port_we),
    .port_addr  (port_addr),
    .port_wdata (port_wdata),
    .gnt_if     (gnt_if),
    .gnt_mem    (gnt_mem),
    .if_stall   (if_stall)
  );

endmodule

// File: rtl/sp_arb_chk.sv
module sp_arb_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          if_req,
  input logic [AW-1:0] if_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          port_en,
  input logic          port_we,
  input logic [AW-1:0] port_addr,
  input logic [DW-1:0] port_wdata,
  input logic          gnt_if,
  input logic          gnt_mem,
  input logic          if_stall
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!port_en && !gnt_if && !gnt_mem && !if_stall && !port_we));

  p_data_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (gnt_mem && port_addr == $past(mem_addr)));

  p_fetch_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && !mem_req && !if_stall) |=> (gnt_if && port_addr == $past(if_addr)));

  p_collide_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && mem_req) |=> if_stall);

  p_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (if_stall && !mem_req) |=> gnt_if);

  p_stall_persist_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (if_stall && mem_req) |=> if_stall);

  p_grant_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_if && gnt_mem));

  p_stall_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    if_stall |-> gnt_mem);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_req && !mem_req && !if_stall) |=> !port_en);

  p_write_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    port_we |-> gnt_mem);

endmodule

bind sp_arb sp_arb_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sp_arb_bench.sv
module sp_arb_bench;

  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          if_req;
  logic [AW-1:0] if_addr;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          port_en;
  logic          port_we;
  logic [AW-1:0] port_addr;
  logic [DW-1:0] port_wdata;
  logic          gnt_if;
  logic          gnt_mem;
  logic          if_stall;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // expected outputs for the next comparison
  logic          e_en, e_we, e_gi, e_gm, e_st;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_wdata;
  string         e_tag;
  int            held_q[$];

  sp_arb #(.AW(AW), .DW(DW)) u_sp_arb (.*);

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic compare();
    checks++;
    if (port_en !== e_en || port_we !== e_we || gnt_if !== e_gi ||
        gnt_mem !== e_gm || if_stall !== e_st || port_addr !== e_addr ||
        port_wdata !== e_wdata) begin
      failures++;
      $display("FAIL %s actual en=%b we=%b gi=%b gm=%b st=%b addr=%h wd=%h expected en=%b we=%b gi=%b gm=%b st=%b addr=%h wd=%h",
               e_tag, port_en, port_we, gnt_if, gnt_mem, if_stall, port_addr, port_wdata,
               e_en, e_we, e_gi, e_gm, e_st, e_addr, e_wdata);
    end
  endtask

  // one cycle: check last result, drive new requests, predict next result
  task automatic step(input bit ir, input int ia, input bit mr, input bit mw,
                      input int ma, input int md);
    bit fv, from_held;
    int fa;
    @(negedge clk);
    compare();
    if_req    = ir;
    if_addr   = AW'(ia);
    mem_req   = mr;
    mem_we    = mw;
    mem_addr  = AW'(ma);
    mem_wdata = DW'(md);
    from_held = held_q.size() > 0;
    fv = from_held || ir;
    fa = from_held ? held_q.pop_front() : ia;
    e_gm = mr;
    e_gi = fv && !mr;
    e_st = fv && mr;
    e_en = fv || mr;
    e_we = mr && mw;
    e_wdata = (mr && mw) ? DW'(md) : '0;
    e_addr = mr ? AW'(ma) : (e_gi ? AW'(fa) : '0);
    if (e_st) held_q.push_back(fa);
    if (e_st && from_held)      e_tag = "R7";
    else if (e_st)              e_tag = "R4";
    else if (mr)                e_tag = "R2";
    else if (e_gi && from_held && ir && ia != fa) e_tag = "R6";
    else if (e_gi && from_held) e_tag = "R5";
    else if (e_gi)              e_tag = "R3";
    else if (mw)                e_tag = "R10";
    else                        e_tag = "R9";
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    if_req = 1'b1; if_addr = 16'h1111;
    mem_req = 1'b1; mem_we = 1'b1; mem_addr = 16'h2222; mem_wdata = 32'hdead;
    e_en = 0; e_we = 0; e_gi = 0; e_gm = 0; e_st = 0; e_addr = '0; e_wdata = '0;
    e_tag = "R1";
    repeat (3) @(negedge clk);
    compare();                         // R1 with active requests
    if_req = 0; mem_req = 0; mem_we = 0; if_addr = '0; mem_addr = '0; mem_wdata = '0;
    rst_n = 1'b1;
    e_tag = "R9";
    step(0, 0, 0, 0, 0, 0);            // idle R9
    step(1, 'h0040, 0, 0, 0, 0);       // fetch alone R3
    step(0, 0, 1, 0, 'h0800, 0);       // load alone R2
    step(0, 0, 1, 1, 'h0804, 'h1234_5678); // store alone R2
    step(1, 'h0044, 1, 0, 'h0900, 0);  // collision R4
    step(1, 'h7777, 0, 0, 0, 0);       // held retried, live ignored R5/R6
    step(1, 'h0048, 1, 1, 'h0a00, 'hcafe); // collision again R4
    step(0, 0, 1, 0, 'h0a04, 0);       // back to back data R7
    step(1, 'h5555, 1, 0, 'h0a08, 0);  // still pending R7/R6
    step(0, 0, 0, 0, 0, 0);            // held retried R5
    step(0, 0, 0, 1, 'h0bbb, 'hffff);  // stray write enable R10
    step(1, 'h004c, 0, 0, 0, 0);       // fetch R3
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 1), $urandom_range(0, 16'hffff), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 16'hffff), $urandom);
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule